// File: doc/BRIEF.md
# Dual-Format Serial Register Port

This block is a slave serial port that gives a host access to a seven-entry register bank. One wire set carries two link formats. In the 4-wire format, data enters on a dedicated input and leaves on a dedicated output, most significant bit first. In the 3-wire format, one bidirectional data line is used, split here into an input, an output and an output enable, and every byte travels least significant bit first. The format is chosen by a mode input. The block takes a snapshot of that input while chip enable is low and keeps it for the whole transaction.

Each transaction opens with an address byte. Bit 7 of that byte marks a write when set and a read when clear. One data byte follows. For a read, the port raises a read strobe once the address byte is complete, loads the byte the bank returns, and shifts it out. For a write, the port raises a write strobe once the eighth data bit has arrived. It does so only when the address is one of the writable locations. The serial inputs are oversampled by the system clock through synchronizers. The port samples data on rising serial-clock edges and updates its output on falling edges. The serial clock idles low.

Top module: `dual_serial_regport`

## Requirements
- R1: Under reset, and after it until a transaction starts, wr_stb, rd_stb, sdo, sdio_o and sdio_oe are all 0.
- R2: In 4-wire mode (mode_3w=0), the address byte and the data byte are both shifted MSB first. In 3-wire mode (mode_3w=1), both are shifted LSB first.
- R3: A write to 80h, 83h, 84h, 85h or 86h produces exactly one wr_stb pulse, one clock wide, after the 16th rising serial-clock edge. While the pulse is high, reg_addr holds the address with bit 7 removed and wr_data holds the received byte.
- R4: Writes aimed at the read-only locations (address byte 81h or 82h) produce no wr_stb, and the contents at 01h and 02h read back unchanged.
- R5: A read of an unmapped address (bit 7 clear, value 07h to 7Fh) returns 00h and produces no rd_stb. A write to an unmapped address (bit 7 set, any value other than those in R3) produces no wr_stb.
- R6: A read of 00h to 06h produces one rd_stb pulse, one clock wide, with reg_addr equal to the address. The byte on rd_data in the following clock is then shifted out during the data phase.
- R7: Dropping chip enable before the 16th bit aborts the transaction. No wr_stb is issued, and the next transaction decodes correctly from its first bit.
- R8: sdio_oe is 1 only in 3-wire mode during the data phase of a read, from the completed address byte until chip enable drops. It is 0 in 4-wire mode and in every write.
- R9: sdo carries data only in 4-wire mode during the data phase of a read. At all other times it is 0, and it is always 0 in 3-wire mode.
- R10: Serial-clock edges after the 16th within one transaction are ignored and produce no further strobe.
- R11: A change on mode_3w while chip enable is high has no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable, high for the duration of a transaction |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, 4-wire mode |
| sdio_i | input | 1 | Input side of the bidirectional data line, 3-wire mode |
| mode_3w | input | 1 | Link format select: 0 = 4-wire, 1 = 3-wire |
| rd_data | input | 8 | Register bank read data for reg_addr, valid the clock after rd_stb |
| sdo | output | 1 | Serial data out, 4-wire mode |
| sdio_o | output | 1 | Output side of the bidirectional data line |
| sdio_oe | output | 1 | Drive enable for the bidirectional data line |
| reg_addr | output | 7 | Register index (address byte without its direction bit) |
| wr_data | output | 8 | Byte to be written, valid with wr_stb |
| wr_stb | output | 1 | One-clock write strobe |
| rd_stb | output | 1 | One-clock read strobe |

## Verification
The assertions assume that the serial clock idles low when chip enable rises, that each serial-clock phase lasts several system clocks longer than the synchronizer depth, and that the bank presents rd_data combinationally from reg_addr. The bench keeps to these assumptions by holding every serial-clock half-period at six system clocks and by driving data only while the serial clock is low. Randomised transactions, with random format, address and data drawn from a seeded generator, are mixed with directed cases: aborted frames, extra clocks, read-only and unmapped addresses, and a mode flip in mid-frame.

// File: rtl/serport_pkg.sv
// Package: shared types and shift helpers for the dual-format serial port.
// Assumes an 8-bit frame for both the address byte and the data byte.
package serport_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(2 * BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Shift one serial bit into a byte register in the selected bit order.
    function automatic byte_t shift_in(byte_t v, logic b, logic lsb_first);
        return lsb_first ? {b, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], b};
    endfunction

    // Advance a transmit register by one bit in the selected bit order.
    function automatic byte_t shift_out(byte_t v, logic lsb_first);
        return lsb_first ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
    endfunction

    // Bit currently presented on the line for the selected bit order.
    function automatic logic line_bit(byte_t v, logic lsb_first);
        return lsb_first ? v[0] : v[BYTE_W-1];
    endfunction

endpackage

// File: rtl/ser_sync.sv
// Module: multi-bit input synchronizer.
// Each bit passes through STAGES flops. All bits share the same latency,
// so levels that change together are seen together. Assumes each input
// holds its level for longer than STAGES clocks.
module ser_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages: settle the captured level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ser_decode.sv
// Module: address decoder for the split read/write register space.
// Reads use indices 0 to NUM_REGS-1 with bit 7 clear. Writes use the same
// indices with bit 7 set, limited to those flagged in WR_MASK. Pure
// combinational logic on the full address byte.
module ser_decode
    import serport_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter logic [(1<<IDX_W)-1:0] WR_MASK = 8'b0111_1001
) (
    input  byte_t addr_byte,
    output logic  rd_ok,
    output logic  wr_ok
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

    logic             upper_zero;
    logic [IDX_W-1:0] idx;

    // Split the byte into its direction bit, unused high bits and index.
    always_comb begin
        idx        = addr_byte[IDX_W-1:0];
        upper_zero = (addr_byte[BYTE_W-2:IDX_W] == '0);
        rd_ok      = !addr_byte[BYTE_W-1] && upper_zero && ({1'b0, idx} < LIMIT);
        wr_ok      = addr_byte[BYTE_W-1] && upper_zero && WR_MASK[idx];
    end

    // R6: a byte is never decoded as both a read and a write.
    always_comb begin
        assert_rd_wr_excl_R6: assert (!(rd_ok && wr_ok));
    end

endmodule

// File: rtl/ser_engine.sv
// Module: bit engine for the dual-format serial port.
// Counts serial-clock edges, assembles the address and data bytes in the
// bit order of the latched mode, raises the strobes and shifts read data
// out on falling edges. Assumes synchronized inputs, a serial clock that
// idles low, and rd_data valid one clock after rd_stb.
module ser_engine
    import serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              sdio_s,
    input  logic              mode_s,
    input  byte_t             rd_data,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output byte_t             addr_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output byte_t             wr_data,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              sdo,
    output logic              sdio_o,
    output logic              sdio_oe
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] DATA_FST  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * BYTE_W - 1);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(2 * BYTE_W);

    logic             sclk_q, mode_l, is_rd, wr_ok_q, rd_ok_q, load_q;
    logic             rise, fall, din, rd_phase, bit_out;
    logic [CNT_W-1:0] cnt;
    byte_t            addr_sh, rx_sh, tx_sh, rx_nxt;

    // Edge detection and the incoming bit for the latched format.
    always_comb begin
        rise      = sclk_s && !sclk_q;
        fall      = !sclk_s && sclk_q;
        din       = mode_l ? sdio_s : sdi_s;
        addr_byte = shift_in(addr_sh, din, mode_l);
        rx_nxt    = shift_in(rx_sh, din, mode_l);
    end

    // Transaction sequencer: counting, capture, strobes and transmit shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            mode_l   <= 1'b0;
            cnt      <= '0;
            addr_sh  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            is_rd    <= 1'b0;
            wr_ok_q  <= 1'b0;
            rd_ok_q  <= 1'b0;
            load_q   <= 1'b0;
            reg_addr <= '0;
            wr_data  <= '0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            load_q <= 1'b0;
            if (!ce_s) begin
                cnt     <= '0;
                mode_l  <= mode_s;
                is_rd   <= 1'b0;
                wr_ok_q <= 1'b0;
                tx_sh   <= '0;
            end else begin
                if (load_q) begin
                    tx_sh <= rd_ok_q ? rd_data : '0;
                end
                if (rise) begin
                    if (cnt < DATA_FST) begin
                        addr_sh <= addr_byte;
                    end else if (cnt < FRAME_END) begin
                        rx_sh <= rx_nxt;
                    end
                    if (cnt < FRAME_END) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                    if (cnt == ADDR_LAST) begin
                        reg_addr <= addr_byte[ADDR_W-1:0];
                        is_rd    <= !addr_byte[BYTE_W-1];
                        wr_ok_q  <= wr_ok;
                        rd_ok_q  <= rd_ok;
                        rd_stb   <= rd_ok;
                        load_q   <= !addr_byte[BYTE_W-1];
                    end
                    if (cnt == DATA_LAST) begin
                        wr_data <= rx_nxt;
                        wr_stb  <= wr_ok_q;
                    end
                end else if (fall && is_rd && cnt > DATA_FST && cnt < FRAME_END) begin
                    tx_sh <= shift_out(tx_sh, mode_l);
                end
            end
        end
    end

    // Output drive: the data line is driven only in a read's data phase.
    always_comb begin
        rd_phase = ce_s && is_rd && (cnt >= DATA_FST);
        bit_out  = line_bit(tx_sh, mode_l);
        sdo      = (rd_phase && !mode_l) ? bit_out : 1'b0;
        sdio_o   = (rd_phase && mode_l) ? bit_out : 1'b0;
        sdio_oe  = rd_phase && mode_l;
    end

    // R3: the write strobe is one clock wide.
    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6: the read strobe is one clock wide.
    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R5: an unmapped read loads a zero byte for transmission.
    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q && !rd_ok_q && ce_s) |=> (tx_sh == '0));

    // R7: a write strobe only follows a cycle in which chip enable was live.
    assert_live_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(ce_s));

    // R8: the line is driven only for a read in 3-wire format.
    assert_oe_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (is_rd && mode_l && ce_s));

    // R10: the edge counter never passes the end of the frame.
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FRAME_END);

    // R11: the latched format cannot change while a frame is live.
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && $past(ce_s)) |-> $stable(mode_l));

endmodule

// File: rtl/dual_serial_regport.sv
// Module: dual-format serial register port (top).
// Synchronizes the serial pins into the system clock domain, decodes the
// split read/write address space and runs the shared bit engine.
// Assumes a serial clock that idles low and phases lasting several clocks.
module dual_serial_regport
    import serport_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_REGS    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              sdio_i,
    input  logic              mode_3w,
    input  logic [7:0]        rd_data,
    output logic              sdo,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic [6:0]        reg_addr,
    output logic [7:0]        wr_data,
    output logic              wr_stb,
    output logic              rd_stb
);

    localparam int PINS = 5;

    logic [PINS-1:0] pins_s;
    byte_t           addr_byte;
    logic            rd_ok, wr_ok;

    ser_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce, sclk, sdi, sdio_i, mode_3w}),
        .q     (pins_s)
    );

    ser_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .addr_byte (addr_byte),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok)
    );

    ser_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (pins_s[4]),
        .sclk_s    (pins_s[3]),
        .sdi_s     (pins_s[2]),
        .sdio_s    (pins_s[1]),
        .mode_s    (pins_s[0]),
        .rd_data   (rd_data),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .addr_byte (addr_byte),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .sdo       (sdo),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe)
    );

    // R4: no write strobe ever reaches a read-only location.
    assert_ro_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (reg_addr != 7'd1 && reg_addr != 7'd2));

    // R3: the two strobes never coincide.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

endmodule

// File: tb/dual_serial_regport_bench.sv
// Bench: seeded random and directed serial transactions against a model.
module dual_serial_regport_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0, sdio_i = 1'b0, mode_3w = 1'b0;
    logic [7:0] rd_data;
    logic       sdo, sdio_o, sdio_oe, wr_stb, rd_stb;
    logic [6:0] reg_addr;
    logic [7:0] wr_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, oe_err = 0, sdo_err = 0;
    logic [6:0] last_wa;
    logic [7:0] last_wd;
    logic [6:0] last_ra;
    logic [7:0] bank  [0:7];
    logic [7:0] model [0:7];
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_serial_regport u_dual_serial_regport (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sdio_i(sdio_i), .mode_3w(mode_3w), .rd_data(rd_data), .sdo(sdo),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
        .wr_data(wr_data), .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    assign rd_data = (reg_addr < 7'd8) ? bank[reg_addr[2:0]] : 8'h00;

    // Register bank stand-in and strobe monitor.
    always @(posedge clk) begin
        if (wr_stb) begin
            bank[reg_addr[2:0]] <= wr_data;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= wr_data;
        end
        if (rd_stb) begin
            rd_cnt  <= rd_cnt + 1;
            last_ra <= reg_addr;
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit f_wr_ok(logic [7:0] a);
        return a[7] && a[6:3] == 4'd0 && (a[2:0] inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6});
    endfunction

    function automatic bit f_rd_ok(logic [7:0] a);
        return !a[7] && a[6:3] == 4'd0 && a[2:0] != 3'd7;
    endfunction

    // One transaction of nbits serial clocks; optional mode flip mid-frame.
    task automatic xfer(input logic m, input logic [7:0] a, input logic [7:0] d,
                        input int nbits, input bit flip, output logic [7:0] got);
        got = 8'h00;
        mode_3w = m;
        clks(4);
        ce = 1'b1;
        clks(6);
        for (int i = 0; i < nbits; i++) begin
            automatic logic [7:0] byt = (i < 8) ? a : d;
            automatic int k = i % 8;
            automatic logic bv = (i < 16) ? (m ? byt[k] : byt[7-k]) : 1'b0;
            automatic bit rphase = (i >= 8) && !a[7];
            if (m) sdio_i = bv; else sdi = bv;
            clks(6);
            if (sdio_oe != (m && rphase)) oe_err++;
            if (sdo != 1'b0 && (m || !rphase)) sdo_err++;
            if (m && sdio_o != 1'b0 && !rphase) sdo_err++;
            if (i >= 8 && i < 16) got[m ? k : 7 - k] = m ? sdio_o : sdo;
            sclk = 1'b1;
            clks(6);
            sclk = 1'b0;
            if (flip && i == 3) mode_3w = !m;
        end
        clks(6);
        ce = 1'b0;
        clks(10);
        mode_3w = m;
    endtask

    // Full transaction checked against the model.
    task automatic run(input logic m, input logic [7:0] a, input logic [7:0] d, string tag);
        automatic int w0 = wr_cnt, r0 = rd_cnt;
        automatic logic [7:0] got;
        xfer(m, a, d, 16, 1'b0, got);
        if (a[7]) begin
            chk(wr_cnt - w0 == (f_wr_ok(a) ? 1 : 0), tag, "write strobes", wr_cnt - w0, f_wr_ok(a));
            if (f_wr_ok(a)) begin
                chk(last_wa == a[6:0] && last_wd == d, tag, "write addr/data",
                    {last_wa, last_wd}, {a[6:0], d});
                model[a[2:0]] = d;
            end
        end else begin
            chk(rd_cnt - r0 == (f_rd_ok(a) ? 1 : 0), tag, "read strobes", rd_cnt - r0, f_rd_ok(a));
            chk(got == (f_rd_ok(a) ? model[a[2:0]] : 8'h00), tag, "read data",
                got, f_rd_ok(a) ? model[a[2:0]] : 8'h00);
        end
    endtask

    initial begin
        automatic int w0;
        automatic logic [7:0] got;
        void'($urandom(32'd4021));
        for (int i = 0; i < 8; i++) begin
            bank[i]  = 8'($urandom);
            model[i] = bank[i];
        end
        clks(5);
        // R1: reset state
        chk(wr_stb == 0 && rd_stb == 0, "R1", "strobes in reset", {wr_stb, rd_stb}, 0);
        chk(sdo == 0 && sdio_o == 0, "R1", "data outs in reset", {sdo, sdio_o}, 0);
        chk(sdio_oe == 0, "R1", "oe in reset", sdio_oe, 0);
        rst_n = 1'b1;
        clks(5);
        chk(wr_stb == 0 && rd_stb == 0 && sdio_oe == 0, "R1", "idle after reset",
            {wr_stb, rd_stb, sdio_oe}, 0);

        // R2, R3, R6: bit order in both formats, write then read back
        run(1'b0, 8'h83, 8'hA5, "R2/R3 spi write");
        run(1'b0, 8'h03, 8'h00, "R2/R6 spi read");
        chk(last_ra == 7'd3, "R6", "read reg_addr", last_ra, 3);
        run(1'b1, 8'h85, 8'h3C, "R2/R3 3-wire write");
        run(1'b1, 8'h05, 8'h00, "R2/R6 3-wire read");
        run(1'b1, 8'h80, 8'h81, "R2 3-wire asymmetric");
        run(1'b0, 8'h00, 8'h00, "R2 spi read cfg");

        // R4: read-only locations
        run(1'b0, 8'h81, 8'h5A, "R4 write 81");
        run(1'b1, 8'h82, 8'hC3, "R4 write 82");
        run(1'b0, 8'h01, 8'h00, "R4 readback 01");
        run(1'b1, 8'h02, 8'h00, "R4 readback 02");

        // R5: unmapped reads and writes
        run(1'b0, 8'h07, 8'h00, "R5 read 07");
        run(1'b1, 8'h5A, 8'h00, "R5 read 5A");
        run(1'b0, 8'h87, 8'h11, "R5 write 87");
        run(1'b1, 8'hC4, 8'h22, "R5 write C4");

        // R7: aborted frame, then a clean one
        w0 = wr_cnt;
        xfer(1'b0, 8'h84, 8'hEE, 12, 1'b0, got);
        chk(wr_cnt == w0, "R7", "strobe after abort", wr_cnt - w0, 0);
        run(1'b0, 8'h04, 8'h00, "R7 read after abort");
        xfer(1'b1, 8'h06, 8'h00, 5, 1'b0, got);
        run(1'b1, 8'h86, 8'h9D, "R7 write after short abort");

        // R10: extra serial clocks
        w0 = wr_cnt;
        xfer(1'b1, 8'h86, 8'h47, 20, 1'b0, got);
        chk(wr_cnt - w0 == 1, "R10", "strobes with extra clocks", wr_cnt - w0, 1);
        chk(last_wd == 8'h47, "R10", "data with extra clocks", last_wd, 8'h47);
        model[6] = 8'h47;

        // R11: mode flip mid-frame
        w0 = wr_cnt;
        xfer(1'b0, 8'h80, 8'h5B, 16, 1'b1, got);
        chk(wr_cnt - w0 == 1 && last_wd == 8'h5B && last_wa == 7'd0, "R11",
            "write with mode flip", {last_wa, last_wd}, 8'h5B);
        model[0] = 8'h5B;
        xfer(1'b1, 8'h00, 8'h00, 16, 1'b1, got);
        chk(got == 8'h5B, "R11", "read with mode flip", got, 8'h5B);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            automatic logic m = 1'($urandom);
            automatic logic [7:0] a = {1'($urandom), 4'd0, 3'($urandom)};
            if ($urandom % 5 == 0) a = 8'($urandom);
            run(m, a, 8'($urandom), "R3/R5/R6 random");
        end

        chk(oe_err == 0, "R8", "oe mismatches", oe_err, 0);
        chk(sdo_err == 0, "R9", "stray data out", sdo_err, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule